// File: doc/BRIEF.md
# Four-Queue Shared-Storage FIFO with Time-Shared Almost-Full Line

This block holds four independent first-in first-out queues of 18-bit words in one storage array. The array is split into four equal regions. The write port and the read port run on unrelated clocks. Each port picks its active queue by presenting an address together with a strobe. The upper address bits name a device and the lowest two bits name a queue. Several instances can therefore sit on one shared address and data bus. Only the instance whose identifier matches the device field stores words, serves reads, and drives the shared active-low almost-full line.

The almost-full line reports the write port's currently selected queue. It follows a fixed two-stage write-clock pipeline, both for writes and for queue switches. A write that crosses the threshold, or a switch to another queue, shows on the line at the second write-clock edge. Read activity reaches the write domain through a Gray-coded pointer and a two-flop synchronizer. Because of this, a read clears the flag only after a few write-clock edges. When the selected queue belongs to another device, the line is released to high impedance on the same two-edge schedule, so that the owner takes it over cleanly.

Each port has a small state machine with four states. PORT_SELECT is entered when the strobe is high. From there, PORT_IDLE is entered when the enable is low. PORT_XFER is entered when the enable is high and the transfer is allowed. PORT_REFUSED is entered when the enable is high but the queue is full, empty or not owned. The transfer strobe is decoded from the next state. Every state can reach every other state in one cycle.

Top module: `mq_af_fifo`

## Requirements
- R1: While reset is low and just after it is released, every queue is empty and both ports select queue 0 of device 0. dout is 0. The shared line is driven high by the instance whose identifier is 0.
- R2: If wadr_stb is high at a write-clock edge, that edge loads the write queue and device from wadr, with the queue in bits [1:0] and the device in the bits above. No word is stored at that edge, even if wen is high.
- R3: If wen is high and wadr_stb is low, din is appended to the selected queue. Reads return each queue's words in write order, and the queues do not affect each other.
- R4: A write to a queue that holds DEPTH words is dropped, and the queue's contents and pointer stay unchanged.
- R5: A read from an empty queue is dropped, and dout keeps its previous value.
- R6: The flag level is low when the selected queue holds DEPTH−AF_OFF words or more. It is high when the queue holds DEPTH−AF_OFF−1 words or fewer.
- R7: A write that brings the selected queue to the threshold makes the line go low at the second write-clock edge after the write edge.
- R8: After a write-queue switch, the line shows the new queue's level from the second write-clock edge after the switch. Until then it keeps showing the old queue's scheduled status.
- R9: A read that takes the count below the threshold leaves the line low through the third write-clock edge after the read edge. The line is high after the fifth write-clock edge.
- R10: Only the instance whose dev_id equals the selected device field stores writes, performs reads and drives af_n. Other instances hold af_n at high impedance. Drive ownership moves on the same two-edge schedule as the flag.
- R11: If radr_stb is high at a read-clock edge, that edge loads the read queue and device from radr, using the same field layout as wadr. No word is read at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| dev_id | input | DEVW | Static identifier of this instance |
| wadr_stb | input | 1 | Write-queue selection strobe |
| wadr | input | DEVW+2 | Write selection address {device, queue} |
| wen | input | 1 | Write enable |
| din | input | DW | Write data |
| radr_stb | input | 1 | Read-queue selection strobe |
| radr | input | DEVW+2 | Read selection address {device, queue} |
| ren | input | 1 | Read enable |
| dout | output | DW | Registered read data |
| af_n | output | 1 | Active-low almost-full line, high impedance when not owned |

## Verification
The hardest case to reach is a read-driven deassertion, because it crosses clock domains. To see the exact edge window, the queue must sit just at the threshold, and the read must land between write-clock edges at a known offset. The bench runs the read clock at a different period, with its edges on half-nanosecond marks, so that no read edge ever coincides with a write edge. It fills a queue to full and then reads it down one word at a time. It counts write-clock edges after the single read that crosses the threshold. Two instances share the flag line. This lets the hand-over between owners, and the refusal of the other device's writes, be seen as a line level and in read-back data.

// File: rtl/mq_pkg.sv
package mq_pkg;
    localparam int QIW = 2;
    localparam int NQ  = 1 << QIW;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_SELECT,
        PORT_XFER,
        PORT_REFUSED
    } port_state_t;
endpackage

// File: rtl/mq_gray_sync.sv
module mq_gray_sync #(
    parameter int PW = 5
) (
    input  logic          dclk,
    input  logic          rst_n,
    input  logic [PW-1:0] src_gray,
    output logic [PW-1:0] dst_bin
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_ff @(posedge dclk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= src_gray;
            sync_q <= meta_q;
        end
    end

    assign dst_bin = gray_to_bin(sync_q);
endmodule

// File: rtl/mq_wr_port.sv
module mq_wr_port import mq_pkg::*; #(
    parameter int DEPTH  = 16,
    parameter int AF_OFF = 2,
    parameter int DEVW   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEVW-1:0]               dev_id,
    input  logic                          adr_stb,
    input  logic [DEVW+QIW-1:0]           adr,
    input  logic                          en,
    input  logic [NQ-1:0][$clog2(DEPTH):0] rptr_bin,
    output logic                          wr_go,
    output logic [QIW+$clog2(DEPTH)-1:0]  wr_slot,
    output logic [NQ-1:0][$clog2(DEPTH):0] wptr_gray,
    output logic                          af_level,
    output logic                          af_drive
);
    localparam int SW  = $clog2(DEPTH);
    localparam int PW  = SW + 1;
    localparam int AW  = DEVW + QIW;
    localparam int THR = DEPTH - AF_OFF;

    port_state_t             st_q, st_d;
    logic [NQ-1:0][PW-1:0]   wbin_q;
    logic [QIW-1:0]          sel_q;
    logic [DEVW-1:0]         seldev_q;
    logic [DEVW-1:0]         dev_p1_q, dev_p2_q;
    logic                    lvl1_q;
    logic [PW-1:0]           cnt_sel;
    logic                    owned;
    logic                    full_sel;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    assign cnt_sel  = wbin_q[sel_q] - rptr_bin[sel_q];
    assign owned    = (seldev_q == dev_id);
    assign full_sel = (cnt_sel == PW'(DEPTH));
    assign wr_slot  = {sel_q, wbin_q[sel_q][SW-1:0]};

    always_comb begin
        if (adr_stb)                st_d = PORT_SELECT;
        else if (!en)               st_d = PORT_IDLE;
        else if (owned && !full_sel) st_d = PORT_XFER;
        else                        st_d = PORT_REFUSED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PORT_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        wr_go = 1'b0;
        unique case (st_d)
            PORT_XFER:                             wr_go = 1'b1;
            PORT_IDLE, PORT_SELECT, PORT_REFUSED:  wr_go = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q    <= '0;
            wptr_gray <= '0;
            sel_q     <= '0;
            seldev_q  <= '0;
        end else begin
            if (st_d == PORT_SELECT) begin
                sel_q    <= adr[QIW-1:0];
                seldev_q <= adr[AW-1:QIW];
            end
            if (wr_go) begin
                wbin_q[sel_q]    <= wbin_q[sel_q] + PW'(1);
                wptr_gray[sel_q] <= to_gray(wbin_q[sel_q] + PW'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl1_q   <= 1'b0;
            af_level <= 1'b1;
            dev_p1_q <= '0;
            dev_p2_q <= '0;
        end else begin
            lvl1_q   <= (cnt_sel >= PW'(THR));
            af_level <= !lvl1_q;
            dev_p1_q <= seldev_q;
            dev_p2_q <= dev_p1_q;
        end
    end

    assign af_drive = (dev_p2_q == dev_id);

    assert_sel_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adr_stb |=> $stable(wbin_q));
    assert_full_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adr_stb && full_sel) |=> $stable(wbin_q));
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_sel <= PW'(DEPTH));
    assert_flag_fall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(af_level) |-> ($past(st_q, 2) == PORT_XFER || $past(st_q, 2) == PORT_SELECT));
endmodule

// File: rtl/mq_rd_port.sv
module mq_rd_port import mq_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int DEVW  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEVW-1:0]               dev_id,
    input  logic                          adr_stb,
    input  logic [DEVW+QIW-1:0]           adr,
    input  logic                          en,
    input  logic [NQ-1:0][$clog2(DEPTH):0] wptr_bin,
    output logic                          rd_go,
    output logic [QIW+$clog2(DEPTH)-1:0]  rd_slot,
    output logic [NQ-1:0][$clog2(DEPTH):0] rptr_gray
);
    localparam int SW = $clog2(DEPTH);
    localparam int PW = SW + 1;
    localparam int AW = DEVW + QIW;

    port_state_t             st_q, st_d;
    logic [NQ-1:0][PW-1:0]   rbin_q;
    logic [QIW-1:0]          sel_q;
    logic [DEVW-1:0]         seldev_q;
    logic                    owned;
    logic                    empty_sel;

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    assign owned     = (seldev_q == dev_id);
    assign empty_sel = (rbin_q[sel_q] == wptr_bin[sel_q]);
    assign rd_slot   = {sel_q, rbin_q[sel_q][SW-1:0]};

    always_comb begin
        if (adr_stb)                  st_d = PORT_SELECT;
        else if (!en)                 st_d = PORT_IDLE;
        else if (owned && !empty_sel) st_d = PORT_XFER;
        else                          st_d = PORT_REFUSED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PORT_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_go = 1'b0;
        unique case (st_d)
            PORT_XFER:                             rd_go = 1'b1;
            PORT_IDLE, PORT_SELECT, PORT_REFUSED:  rd_go = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q    <= '0;
            rptr_gray <= '0;
            sel_q     <= '0;
            seldev_q  <= '0;
        end else begin
            if (st_d == PORT_SELECT) begin
                sel_q    <= adr[QIW-1:0];
                seldev_q <= adr[AW-1:QIW];
            end
            if (rd_go) begin
                rbin_q[sel_q]    <= rbin_q[sel_q] + PW'(1);
                rptr_gray[sel_q] <= to_gray(rbin_q[sel_q] + PW'(1));
            end
        end
    end

    assert_sel_no_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        adr_stb |=> $stable(rbin_q));
    assert_empty_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adr_stb && empty_sel) |=> $stable(rbin_q));
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_bin[sel_q] - rbin_q[sel_q]) <= PW'(DEPTH));
endmodule

// File: rtl/mq_af_fifo.sv
module mq_af_fifo import mq_pkg::*; #(
    parameter int DW     = 18,
    parameter int DEPTH  = 16,
    parameter int AF_OFF = 2,
    parameter int DEVW   = 2
) (
    input  logic                  wclk,
    input  logic                  rclk,
    input  logic                  rst_n,
    input  logic [DEVW-1:0]       dev_id,
    input  logic                  wadr_stb,
    input  logic [DEVW+QIW-1:0]   wadr,
    input  logic                  wen,
    input  logic [DW-1:0]         din,
    input  logic                  radr_stb,
    input  logic [DEVW+QIW-1:0]   radr,
    input  logic                  ren,
    output logic [DW-1:0]         dout,
    output logic                  af_n
);
    localparam int SW    = $clog2(DEPTH);
    localparam int PW    = SW + 1;
    localparam int SLOTS = NQ * DEPTH;

    logic [NQ-1:0][PW-1:0] wgray, rgray, wbin_rd, rbin_wr;
    logic                  wr_go, rd_go;
    logic [QIW+SW-1:0]     wr_slot, rd_slot;
    logic                  af_level, af_drive;
    logic [DW-1:0]         store [SLOTS];

    for (genvar q = 0; q < NQ; q++) begin : g_cross
        mq_gray_sync #(.PW(PW)) u_w2r (
            .dclk(rclk), .rst_n(rst_n), .src_gray(wgray[q]), .dst_bin(wbin_rd[q])
        );
        mq_gray_sync #(.PW(PW)) u_r2w (
            .dclk(wclk), .rst_n(rst_n), .src_gray(rgray[q]), .dst_bin(rbin_wr[q])
        );
    end

    mq_wr_port #(.DEPTH(DEPTH), .AF_OFF(AF_OFF), .DEVW(DEVW)) u_wr (
        .clk(wclk), .rst_n(rst_n), .dev_id(dev_id), .adr_stb(wadr_stb), .adr(wadr),
        .en(wen), .rptr_bin(rbin_wr), .wr_go(wr_go), .wr_slot(wr_slot),
        .wptr_gray(wgray), .af_level(af_level), .af_drive(af_drive)
    );

    mq_rd_port #(.DEPTH(DEPTH), .DEVW(DEVW)) u_rd (
        .clk(rclk), .rst_n(rst_n), .dev_id(dev_id), .adr_stb(radr_stb), .adr(radr),
        .en(ren), .wptr_bin(wbin_rd), .rd_go(rd_go), .rd_slot(rd_slot),
        .rptr_gray(rgray)
    );

    always_ff @(posedge wclk) begin
        if (wr_go) store[wr_slot] <= din;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)     dout <= '0;
        else if (rd_go) dout <= store[rd_slot];
    end

    assign af_n = af_drive ? af_level : 1'bz;
endmodule

// File: tb/test_mq_af_fifo.sv
`timescale 1ns/1ps
module test_mq_af_fifo;
    localparam int DW = 18;
    localparam int DEPTH = 8;
    localparam int AF_OFF = 2;
    localparam int DEVW = 2;
    localparam int NSTEP = 21;

    // entry: [24] strobe, [23:20] address {dev,queue}, [19] wen, [18:1] data, [0] expected line
    localparam logic [24:0] STEPS [NSTEP] = '{
        {1'b1, 4'h1, 1'b0, 18'h000, 1'b1},
        {1'b0, 4'h1, 1'b1, 18'h101, 1'b1},
        {1'b0, 4'h1, 1'b1, 18'h102, 1'b1},
        {1'b0, 4'h1, 1'b1, 18'h103, 1'b1},
        {1'b0, 4'h1, 1'b1, 18'h104, 1'b1},
        {1'b0, 4'h1, 1'b1, 18'h105, 1'b1},
        {1'b0, 4'h1, 1'b1, 18'h106, 1'b1},
        {1'b0, 4'h0, 1'b0, 18'h000, 1'b1},
        {1'b0, 4'h0, 1'b0, 18'h000, 1'b0},
        {1'b1, 4'h2, 1'b1, 18'h109, 1'b0},
        {1'b0, 4'h0, 1'b1, 18'h10A, 1'b0},
        {1'b1, 4'h1, 1'b0, 18'h000, 1'b1},
        {1'b0, 4'h0, 1'b0, 18'h000, 1'b1},
        {1'b0, 4'h0, 1'b0, 18'h000, 1'b0},
        {1'b1, 4'h4, 1'b0, 18'h000, 1'b0},
        {1'b0, 4'h0, 1'b0, 18'h000, 1'b0},
        {1'b0, 4'h0, 1'b0, 18'h000, 1'b1},
        {1'b0, 4'h0, 1'b1, 18'h111, 1'b1},
        {1'b1, 4'h1, 1'b0, 18'h000, 1'b1},
        {1'b0, 4'h0, 1'b0, 18'h000, 1'b1},
        {1'b0, 4'h0, 1'b0, 18'h000, 1'b0}
    };

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wadr_stb = 1'b0;
    logic [3:0]    wadr = '0;
    logic          wen = 1'b0;
    logic [DW-1:0] din = '0;
    logic          radr_stb = 1'b0;
    logic [3:0]    radr = '0;
    logic          ren = 1'b0;
    logic [DW-1:0] dout_a, dout_b;
    wire           af_line;
    int            checks = 0;
    int            errors = 0;

    always #4 wclk = ~wclk;
    initial begin
        #2.5;
        forever #5 rclk = ~rclk;
    end

    mq_af_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_OFF(AF_OFF), .DEVW(DEVW)) i_mq_af_fifo (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .dev_id(2'd0),
        .wadr_stb(wadr_stb), .wadr(wadr), .wen(wen), .din(din),
        .radr_stb(radr_stb), .radr(radr), .ren(ren), .dout(dout_a), .af_n(af_line)
    );

    mq_af_fifo #(.DW(DW), .DEPTH(DEPTH), .AF_OFF(AF_OFF), .DEVW(DEVW)) i_mq_af_fifo_peer (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .dev_id(2'd1),
        .wadr_stb(wadr_stb), .wadr(wadr), .wen(wen), .din(din),
        .radr_stb(radr_stb), .radr(radr), .ren(ren), .dout(dout_b), .af_n(af_line)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wstep(input logic stb, input logic [3:0] a, input logic e, input logic [DW-1:0] d);
        @(negedge wclk);
        wadr_stb = stb; wadr = a; wen = e; din = d;
        @(posedge wclk);
        #1;
        wadr_stb = 1'b0; wen = 1'b0;
    endtask

    task automatic rstep(input logic stb, input logic [3:0] a, input logic e);
        @(negedge rclk);
        radr_stb = stb; radr = a; ren = e;
        @(posedge rclk);
        #1;
        radr_stb = 1'b0; ren = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge wclk);
        @(negedge wclk);
        rst_n = 1'b1;
        #1;
        check("R1 line after reset", {31'b0, af_line}, 32'h1);
        check("R1 dout A after reset", 32'(dout_a), 32'h0);
        check("R1 dout B after reset", 32'(dout_b), 32'h0);

        // R6 R7 R8 R10 table: line level after each write-clock edge
        for (int i = 0; i < NSTEP; i++) begin
            wstep(STEPS[i][24], STEPS[i][23:20], STEPS[i][19], STEPS[i][18:1]);
            check($sformatf("R6/R7/R8/R10 table step %0d", i), {31'b0, af_line}, {31'b0, STEPS[i][0]});
        end

        // fill A queue 1 to full; the third write is dropped (R4)
        wstep(1'b0, 4'h0, 1'b1, 18'h201);
        wstep(1'b0, 4'h0, 1'b1, 18'h202);
        wstep(1'b0, 4'h0, 1'b1, 18'h2FF);
        repeat (3) wstep(1'b0, 4'h0, 1'b0, 18'h0);
        check("R6 line low while full", {31'b0, af_line}, 32'h0);

        // R11: selection edge with ren high reads nothing
        rstep(1'b1, 4'h1, 1'b1);
        check("R11 no read on select", 32'(dout_a), 32'h0);
        rstep(1'b0, 4'h0, 1'b1);
        check("R3 first word", 32'(dout_a), 32'h101);
        rstep(1'b0, 4'h0, 1'b1);
        check("R3 second word", 32'(dout_a), 32'h102);
        rstep(1'b0, 4'h0, 1'b1);
        check("R3 third word", 32'(dout_a), 32'h103);
        repeat (3) @(posedge wclk);
        #1;
        check("R9 still low at third write edge", {31'b0, af_line}, 32'h0);
        repeat (2) @(posedge wclk);
        #1;
        check("R9 high after fifth write edge", {31'b0, af_line}, 32'h1);

        rstep(1'b0, 4'h0, 1'b1);
        check("R3 word 4", 32'(dout_a), 32'h104);
        rstep(1'b0, 4'h0, 1'b1);
        check("R3 word 5", 32'(dout_a), 32'h105);
        rstep(1'b0, 4'h0, 1'b1);
        check("R3 word 6", 32'(dout_a), 32'h106);
        rstep(1'b0, 4'h0, 1'b1);
        check("R3 word 7", 32'(dout_a), 32'h201);
        rstep(1'b0, 4'h0, 1'b1);
        check("R4 last stored word", 32'(dout_a), 32'h202);
        rstep(1'b0, 4'h0, 1'b1);
        check("R5 empty read holds dout", 32'(dout_a), 32'h202);

        rstep(1'b1, 4'h2, 1'b0);
        rstep(1'b0, 4'h0, 1'b1);
        check("R2 queue 2 holds only the post-select word", 32'(dout_a), 32'h10A);
        rstep(1'b0, 4'h0, 1'b1);
        check("R5 queue 2 now empty", 32'(dout_a), 32'h10A);

        rstep(1'b1, 4'h4, 1'b0);
        rstep(1'b0, 4'h0, 1'b1);
        check("R10 peer serves its own queue", 32'(dout_b), 32'h111);
        check("R10 non-owner does not read", 32'(dout_a), 32'h10A);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule